// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Scaler

This block combines an 8-bit timer/counter and a watchdog. They share one programmable scaler. A processor core drives one step pulse for each instruction it retires, together with the number of cycles that instruction took. On each step the block does three things in order. First it applies the instruction's side effects: a control write, a timer load, a watchdog clear or entry into sleep. Next it advances the timer. Last it advances the watchdog.

The timer counts either instruction cycles or edges of an external pin. The pin is sampled once per step and compared with its previous sample. The scaler belongs to one side at a time:

- **On the timer side** it is a prescaler. The timer advances by the number of whole periods that fit in the scaler sum, and the scaler keeps the remainder.
- **On the watchdog side** it is a postscaler. It counts watchdog overflows, and a time-out fires once the programmed number of overflows is reached.

A time-out pulses a reset request, clears the time-out flag, and returns the control byte, scaler and hold-off to their reset values. While power-down is active, only the watchdog runs, at one tick per step.

Top module: `tmr_wdog`

## Requirements
- R1: After synchronous reset the timer reads 0, the time-out flag and the power-down flag read 1, the reset request reads 0, and the control byte is 0xFF (pin source, falling edge, scaler on watchdog, rate 7).
- R2: The control byte uses these fields. Bits 2..0 hold the rate. Bit 3 assigns the scaler (1 = watchdog, 0 = timer). Bit 4 selects the pin edge (1 = falling, 0 = rising). Bit 5 selects the source (1 = pin, 0 = instruction cycles). A control write takes effect for the same step that carries it.
- R3: In cycle mode with the scaler on the watchdog, each awake step adds its cycle count (1 or 2) to the timer, which wraps from 0xFF to 0x00. The timer changes only on steps.
- R4: With the scaler on the timer, the scaler sum is the old scaler value plus the step's ticks. The timer gains the number of whole periods of 2 << rate contained in that sum, and the scaler keeps the remainder.
- R5: In pin mode a step counts one tick when the pin differs from its sample at the previous pin-mode step in the selected direction. A change in the other direction counts nothing.
- R6: A timer write loads the data, and neither that step nor the next cycle-mode step advances the timer. When the scaler is on the timer, the write also zeroes it.
- R7: With the watchdog enabled and the core awake, the watchdog advances by each step's cycle count. It overflows once WDT_PERIOD cycles accumulate. Without the postscaler every overflow is a time-out. With the watchdog disabled no time-out occurs.
- R8: With the scaler on the watchdog, a time-out occurs on overflow number 1 << rate.
- R9: A clear-watchdog step zeroes the watchdog count, zeroes the scaler if it is on the watchdog, and sets both flags. A clear-watchdog or sleep step does not advance the watchdog.
- R10: A sleep step zeroes the watchdog count if the watchdog is enabled, zeroes the scaler if it is on the watchdog, sets the time-out flag and clears the power-down flag.
- R11: While the power-down flag is 0, the timer is frozen, timer writes, control writes, clear-watchdog and sleep are ignored, and the watchdog advances by exactly 1 per step whatever the cycle count.
- R12: A time-out raises the reset request for exactly the one cycle after its step. It clears the time-out flag, sets the power-down flag, restores the control byte to 0xFF and zeroes the scaler, hold-off and pin sample. The timer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One instruction retired this clock |
| step_cyc_i | input | CYC_W | Cycles taken by that instruction |
| ext_pin_i | input | 1 | External count pin, sampled on steps |
| ctrl_we_i | input | 1 | Control byte write with this step |
| ctrl_wdata_i | input | 8 | Control byte data |
| tmr_we_i | input | 1 | Timer write with this step |
| tmr_wdata_i | input | TMR_W | Timer write data |
| clrwdt_i | input | 1 | Step is a clear-watchdog command |
| sleep_i | input | 1 | Step is a sleep command |
| wdt_en_i | input | 1 | Watchdog enable |
| tmr_o | output | TMR_W | Timer value |
| wdt_rst_o | output | 1 | One-cycle reset request on time-out |
| to_flag_o | output | 1 | Time-out flag (0 after a time-out) |
| pd_flag_o | output | 1 | Power-down flag (0 while asleep) |

## Verification
The assertions check on every cycle the properties that need no counting:

- the reset request lasts a single cycle and leaves the flags at time-out and awake;
- the timer holds still between steps and throughout sleep;
- sleep and clear-watchdog steps set the flags as required;
- a cycle-mode timer write lands exactly;
- sleep ends only through a time-out.

The bench scenarios cover what depends on accumulated history:

- prescaler remainders and multi-period carries after a reassignment;
- the two-step hold-off;
- edge direction against the previous pin sample;
- the exact step on which an overflow or postscaled time-out lands;
- scaler clearing by clear-watchdog;
- the control byte returning to its default after a time-out.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;

    localparam int CTRL_W = 8;
    localparam int RATE_W = 3;
    localparam int SCL_W  = 1 << RATE_W;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'hFF;

    typedef struct packed {
        logic [1:0]        spare;
        logic              ext_src;
        logic              fall_edge;
        logic              scl_wdog;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef enum logic [1:0] {
        HOLD_IDLE = 2'd0,
        HOLD_LAST = 2'd1,
        HOLD_FULL = 2'd2
    } hold_e;

    typedef struct packed {
        logic to;
        logic pd;
    } pwr_t;

    function automatic logic edge_hit(logic prev, logic cur, logic fall);
        return fall ? (prev & ~cur) : (~prev & cur);
    endfunction

    function automatic logic [SCL_W-1:0] post_limit(logic [RATE_W-1:0] rate);
        return SCL_W'(1) << rate;
    endfunction

endpackage

// File: rtl/tmr_wdog_cmd.sv
module tmr_wdog_cmd
    import tmr_wdog_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int WDT_W = 16
) (
    input  logic                 step_i,
    input  logic                 awake_i,
    input  logic                 ctrl_we_i,
    input  logic [CTRL_W-1:0]    ctrl_wdata_i,
    input  logic                 tmr_we_i,
    input  logic [TMR_W-1:0]     tmr_wdata_i,
    input  logic                 clrwdt_i,
    input  logic                 sleep_i,
    input  logic                 wdt_en_i,
    input  ctrl_t                ctrl_q_i,
    input  logic [TMR_W-1:0]     tmr_q_i,
    input  logic [SCL_W-1:0]     scl_q_i,
    input  hold_e                hold_q_i,
    input  logic [WDT_W-1:0]     wdt_q_i,
    input  pwr_t                 pwr_q_i,
    output ctrl_t                ctrl_o,
    output logic [TMR_W-1:0]     tmr_o,
    output logic [SCL_W-1:0]     scl_o,
    output hold_e                hold_o,
    output logic [WDT_W-1:0]     wdt_o,
    output pwr_t                 pwr_o,
    output logic                 wdt_adv_o
);

    logic exec;
    assign exec = step_i && awake_i;

    always_comb begin
        ctrl_o = ctrl_q_i;
        tmr_o  = tmr_q_i;
        scl_o  = scl_q_i;
        hold_o = hold_q_i;
        wdt_o  = wdt_q_i;
        pwr_o  = pwr_q_i;
        if (exec) begin
            if (ctrl_we_i) begin
                ctrl_o = ctrl_t'(ctrl_wdata_i);
            end
            if (tmr_we_i) begin
                tmr_o  = tmr_wdata_i;
                hold_o = HOLD_FULL;
                if (!ctrl_o.scl_wdog) begin
                    scl_o = '0;
                end
            end
            if (clrwdt_i) begin
                wdt_o = '0;
                if (ctrl_o.scl_wdog) begin
                    scl_o = '0;
                end
                pwr_o.to = 1'b1;
                pwr_o.pd = 1'b1;
            end
            if (sleep_i) begin
                if (wdt_en_i) begin
                    wdt_o = '0;
                end
                if (ctrl_o.scl_wdog) begin
                    scl_o = '0;
                end
                pwr_o.to = 1'b1;
                pwr_o.pd = 1'b0;
            end
        end
    end

    assign wdt_adv_o = step_i && wdt_en_i && (!awake_i || !(clrwdt_i || sleep_i));

endmodule

// File: rtl/tmr_wdog_count.sv
module tmr_wdog_count
    import tmr_wdog_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int CYC_W = 2
) (
    input  logic                 run_i,
    input  logic [CYC_W-1:0]     cyc_i,
    input  logic                 pin_i,
    input  logic                 pin_q_i,
    input  ctrl_t                ctrl_i,
    input  logic [TMR_W-1:0]     tmr_i,
    input  logic [SCL_W-1:0]     scl_i,
    input  hold_e                hold_i,
    output logic [TMR_W-1:0]     tmr_o,
    output logic [SCL_W-1:0]     scl_o,
    output hold_e                hold_o,
    output logic                 pin_o
);

    localparam int SUM_W = SCL_W + CYC_W;

    logic [CYC_W-1:0] ticks;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] periods;
    logic [SUM_W-1:0] rem_mask;
    logic [SUM_W-1:0] rem;

    always_comb begin
        pin_o  = pin_q_i;
        hold_o = hold_i;
        ticks  = '0;
        if (run_i) begin
            if (ctrl_i.ext_src) begin
                pin_o = pin_i;
                ticks = CYC_W'(edge_hit(pin_q_i, pin_i, ctrl_i.fall_edge));
            end else if (hold_i != HOLD_IDLE) begin
                hold_o = (hold_i == HOLD_FULL) ? HOLD_LAST : HOLD_IDLE;
            end else begin
                ticks = cyc_i;
            end
        end
    end

    always_comb begin
        sum      = SUM_W'(scl_i) + SUM_W'(ticks);
        periods  = sum >> (32'(ctrl_i.rate) + 32'd1);
        rem_mask = (SUM_W'(1) << (32'(ctrl_i.rate) + 32'd1)) - SUM_W'(1);
        rem      = sum & rem_mask;
        if (ctrl_i.scl_wdog) begin
            tmr_o = tmr_i + TMR_W'(ticks);
            scl_o = scl_i;
        end else begin
            tmr_o = tmr_i + TMR_W'(periods);
            scl_o = SCL_W'(rem);
        end
    end

endmodule

// File: rtl/tmr_wdog_guard.sv
module tmr_wdog_guard
    import tmr_wdog_pkg::*;
#(
    parameter int WDT_PERIOD = 18000,
    parameter int WDT_W      = 16,
    parameter int CYC_W      = 2
) (
    input  logic                 adv_i,
    input  logic                 asleep_i,
    input  logic [CYC_W-1:0]     cyc_i,
    input  ctrl_t                ctrl_i,
    input  logic [SCL_W-1:0]     scl_i,
    input  logic [WDT_W-1:0]     wdt_i,
    output logic [SCL_W-1:0]     scl_o,
    output logic [WDT_W-1:0]     wdt_o,
    output logic                 timeout_o
);

    localparam int SW = WDT_W + 1;

    logic [WDT_W-1:0] inc;
    logic [SW-1:0]    sum;
    logic             ovf;
    logic [SCL_W:0]   post_nxt;

    always_comb begin
        inc       = asleep_i ? WDT_W'(1) : WDT_W'(cyc_i);
        sum       = SW'(wdt_i) + SW'(inc);
        ovf       = adv_i && (sum >= SW'(WDT_PERIOD));
        post_nxt  = {1'b0, scl_i} + {{SCL_W{1'b0}}, 1'b1};
        wdt_o     = wdt_i;
        scl_o     = scl_i;
        timeout_o = 1'b0;
        if (adv_i) begin
            wdt_o = ovf ? WDT_W'(sum - SW'(WDT_PERIOD)) : WDT_W'(sum);
        end
        if (ovf) begin
            if (ctrl_i.scl_wdog) begin
                if (post_nxt >= {1'b0, post_limit(ctrl_i.rate)}) begin
                    timeout_o = 1'b1;
                    scl_o     = '0;
                end else begin
                    scl_o = SCL_W'(post_nxt);
                end
            end else begin
                timeout_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tmr_wdog_pkg::*;
#(
    parameter int TMR_W      = 8,
    parameter int CYC_W      = 2,
    parameter int WDT_PERIOD = 18000
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 step_i,
    input  logic [CYC_W-1:0]     step_cyc_i,
    input  logic                 ext_pin_i,
    input  logic                 ctrl_we_i,
    input  logic [CTRL_W-1:0]    ctrl_wdata_i,
    input  logic                 tmr_we_i,
    input  logic [TMR_W-1:0]     tmr_wdata_i,
    input  logic                 clrwdt_i,
    input  logic                 sleep_i,
    input  logic                 wdt_en_i,
    output logic [TMR_W-1:0]     tmr_o,
    output logic                 wdt_rst_o,
    output logic                 to_flag_o,
    output logic                 pd_flag_o
);

    localparam int WDT_W = $clog2(WDT_PERIOD + 4);

    ctrl_t              ctrl_q, ctrl_c;
    logic [TMR_W-1:0]   tmr_q, tmr_c, tmr_n;
    logic [SCL_W-1:0]   scl_q, scl_c, scl_t, scl_n;
    hold_e              hold_q, hold_c, hold_n;
    logic [WDT_W-1:0]   wdt_q, wdt_c, wdt_n;
    pwr_t               pwr_q, pwr_c;
    logic               pin_q, pin_n;
    logic               rst_req_q;
    logic               wdt_adv;
    logic               timeout;
    logic               awake;
    logic               src_is_pin;

    assign awake      = pwr_q.pd;
    assign src_is_pin = ctrl_q.ext_src;

    tmr_wdog_cmd #(
        .TMR_W (TMR_W),
        .WDT_W (WDT_W)
    ) u_cmd (
        .step_i       (step_i),
        .awake_i      (awake),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .tmr_we_i     (tmr_we_i),
        .tmr_wdata_i  (tmr_wdata_i),
        .clrwdt_i     (clrwdt_i),
        .sleep_i      (sleep_i),
        .wdt_en_i     (wdt_en_i),
        .ctrl_q_i     (ctrl_q),
        .tmr_q_i      (tmr_q),
        .scl_q_i      (scl_q),
        .hold_q_i     (hold_q),
        .wdt_q_i      (wdt_q),
        .pwr_q_i      (pwr_q),
        .ctrl_o       (ctrl_c),
        .tmr_o        (tmr_c),
        .scl_o        (scl_c),
        .hold_o       (hold_c),
        .wdt_o        (wdt_c),
        .pwr_o        (pwr_c),
        .wdt_adv_o    (wdt_adv)
    );

    tmr_wdog_count #(
        .TMR_W (TMR_W),
        .CYC_W (CYC_W)
    ) u_count (
        .run_i   (step_i && awake),
        .cyc_i   (step_cyc_i),
        .pin_i   (ext_pin_i),
        .pin_q_i (pin_q),
        .ctrl_i  (ctrl_c),
        .tmr_i   (tmr_c),
        .scl_i   (scl_c),
        .hold_i  (hold_c),
        .tmr_o   (tmr_n),
        .scl_o   (scl_t),
        .hold_o  (hold_n),
        .pin_o   (pin_n)
    );

    tmr_wdog_guard #(
        .WDT_PERIOD (WDT_PERIOD),
        .WDT_W      (WDT_W),
        .CYC_W      (CYC_W)
    ) u_guard (
        .adv_i     (wdt_adv),
        .asleep_i  (!awake),
        .cyc_i     (step_cyc_i),
        .ctrl_i    (ctrl_c),
        .scl_i     (scl_t),
        .wdt_i     (wdt_c),
        .scl_o     (scl_n),
        .wdt_o     (wdt_n),
        .timeout_o (timeout)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q    <= ctrl_t'(CTRL_RST);
            tmr_q     <= '0;
            scl_q     <= '0;
            hold_q    <= HOLD_IDLE;
            wdt_q     <= '0;
            pin_q     <= 1'b0;
            pwr_q     <= '{to: 1'b1, pd: 1'b1};
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= timeout;
            tmr_q     <= tmr_n;
            wdt_q     <= wdt_n;
            if (timeout) begin
                ctrl_q <= ctrl_t'(CTRL_RST);
                scl_q  <= '0;
                hold_q <= HOLD_IDLE;
                pin_q  <= 1'b0;
                pwr_q  <= '{to: 1'b0, pd: 1'b1};
            end else begin
                ctrl_q <= ctrl_c;
                scl_q  <= scl_n;
                hold_q <= hold_n;
                pin_q  <= pin_n;
                pwr_q  <= pwr_c;
            end
        end
    end

    assign tmr_o     = tmr_q;
    assign wdt_rst_o = rst_req_q;
    assign to_flag_o = pwr_q.to;
    assign pd_flag_o = pwr_q.pd;

endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             step_i,
    input logic             ctrl_we_i,
    input logic             tmr_we_i,
    input logic [TMR_W-1:0] tmr_wdata_i,
    input logic             clrwdt_i,
    input logic             sleep_i,
    input logic             src_is_pin,
    input logic [TMR_W-1:0] tmr_o,
    input logic             wdt_rst_o,
    input logic             to_flag_o,
    input logic             pd_flag_o
);

    AST_RST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |=> !wdt_rst_o); // R12

    AST_RST_FLAGS: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |-> (!to_flag_o && pd_flag_o)); // R12

    AST_IDLE_TMR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(tmr_o)); // R3

    AST_ASLEEP_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !pd_flag_o) |=> $stable(tmr_o)); // R11

    AST_WAKE_BY_TIMEOUT: assert property (@(posedge clk_i) disable iff (rst_i)
        !pd_flag_o |=> (!pd_flag_o || wdt_rst_o)); // R11

    AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && sleep_i && !clrwdt_i && pd_flag_o) |=> (!pd_flag_o && to_flag_o)); // R10

    AST_CLEAR_FLAGS: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && clrwdt_i && !sleep_i && pd_flag_o) |=> (to_flag_o && pd_flag_o)); // R9

    AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && tmr_we_i && pd_flag_o && !ctrl_we_i && !src_is_pin)
        |=> (tmr_o == $past(tmr_wdata_i))); // R6

endmodule

bind tmr_wdog tmr_wdog_chk #(.TMR_W(TMR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .step_i      (step_i),
    .ctrl_we_i   (ctrl_we_i),
    .tmr_we_i    (tmr_we_i),
    .tmr_wdata_i (tmr_wdata_i),
    .clrwdt_i    (clrwdt_i),
    .sleep_i     (sleep_i),
    .src_is_pin  (src_is_pin),
    .tmr_o       (tmr_o),
    .wdt_rst_o   (wdt_rst_o),
    .to_flag_o   (to_flag_o),
    .pd_flag_o   (pd_flag_o)
);

// File: tb/tmr_wdog_tb_top.sv
module tmr_wdog_tb_top;

    localparam int PERIOD = 10;
    localparam int NVEC   = 23;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       step_i = 1'b0;
    logic [1:0] step_cyc_i = 2'd1;
    logic       ext_pin_i = 1'b0;
    logic       ctrl_we_i = 1'b0;
    logic [7:0] ctrl_wdata_i = 8'h00;
    logic       tmr_we_i = 1'b0;
    logic [7:0] tmr_wdata_i = 8'h00;
    logic       clrwdt_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       wdt_en_i = 1'b0;
    logic [7:0] tmr_o;
    logic       wdt_rst_o;
    logic       to_flag_o;
    logic       pd_flag_o;

    int  n_checks = 0;
    int  n_errors = 0;
    logic rst_seen = 1'b0;
    logic [7:0] t_snap;

    always #5 clk_i = ~clk_i;

    tmr_wdog #(.TMR_W(8), .CYC_W(2), .WDT_PERIOD(PERIOD)) dut_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .step_i       (step_i),
        .step_cyc_i   (step_cyc_i),
        .ext_pin_i    (ext_pin_i),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .tmr_we_i     (tmr_we_i),
        .tmr_wdata_i  (tmr_wdata_i),
        .clrwdt_i     (clrwdt_i),
        .sleep_i      (sleep_i),
        .wdt_en_i     (wdt_en_i),
        .tmr_o        (tmr_o),
        .wdt_rst_o    (wdt_rst_o),
        .to_flag_o    (to_flag_o),
        .pd_flag_o    (pd_flag_o)
    );

    // {ctrl_we, ctrl[7:0], tmr_we, tmr_data[7:0], cyc[1:0], pin, expected timer[7:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 8'h08, 1'b0, 8'h00, 2'd1, 1'b0, 8'h01},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd2, 1'b0, 8'h03},
        {1'b0, 8'h00, 1'b1, 8'hFE, 2'd1, 1'b0, 8'hFE},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b0, 8'hFE},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd2, 1'b0, 8'h00},
        {1'b1, 8'h01, 1'b0, 8'h00, 2'd1, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd2, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd2, 1'b0, 8'h01},
        {1'b0, 8'h00, 1'b1, 8'h10, 2'd1, 1'b0, 8'h10},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd2, 1'b0, 8'h10},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd2, 1'b0, 8'h10},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b0, 8'h10},
        {1'b1, 8'h28, 1'b0, 8'h00, 2'd1, 1'b0, 8'h10},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b1, 8'h11},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b1, 8'h11},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b0, 8'h11},
        {1'b1, 8'h38, 1'b0, 8'h00, 2'd1, 1'b1, 8'h11},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b0, 8'h12},
        {1'b1, 8'h20, 1'b0, 8'h00, 2'd1, 1'b1, 8'h14},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b0, 8'h14},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b1, 8'h14},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b0, 8'h14},
        {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 1'b1, 8'h15}
    };

    function automatic string vec_req(int i);
        if (i < 2)  return "R2 R3";
        if (i < 4)  return "R6";
        if (i == 4) return "R3";
        if (i < 8)  return "R4";
        if (i < 12) return "R6";
        if (i < 18) return "R5";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        rst_i    = 1'b0;
        rst_seen = 1'b0;
    endtask

    task automatic do_step(input logic [1:0] cyc, input logic pin,
                           input logic cwe, input logic [7:0] cd,
                           input logic twe, input logic [7:0] td,
                           input logic clr, input logic slp);
        step_i       = 1'b1;
        step_cyc_i   = cyc;
        ext_pin_i    = pin;
        ctrl_we_i    = cwe;
        ctrl_wdata_i = cd;
        tmr_we_i     = twe;
        tmr_wdata_i  = td;
        clrwdt_i     = clr;
        sleep_i      = slp;
        @(posedge clk_i);
        @(negedge clk_i);
        step_i    = 1'b0;
        ctrl_we_i = 1'b0;
        tmr_we_i  = 1'b0;
        clrwdt_i  = 1'b0;
        sleep_i   = 1'b0;
        if (wdt_rst_o) rst_seen = 1'b1;
    endtask

    task automatic plain_steps(input int n, input logic [1:0] cyc);
        for (int k = 0; k < n; k++) begin
            do_step(cyc, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: bench hung, got running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 timer", 32'(tmr_o), 32'h00);
        check("R1 to flag", 32'(to_flag_o), 32'd1);
        check("R1 pd flag", 32'(pd_flag_o), 32'd1);
        check("R1 reset request", 32'(wdt_rst_o), 32'd0);
        // R1 default control: pin source, falling edge, scaler on watchdog
        do_step(2'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R1 default rising ignored", 32'(tmr_o), 32'h00);
        do_step(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R1 default falling counted", 32'(tmr_o), 32'h01);

        // vector walk: timer paths
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            do_step(VEC[i][10:9], VEC[i][8], VEC[i][28], VEC[i][27:20],
                    VEC[i][19], VEC[i][18:11], 1'b0, 1'b0);
            check(vec_req(i), 32'(tmr_o), 32'(VEC[i][7:0]));
        end

        // R7 overflow exactly at WDT_PERIOD cycles, R12 time-out effects
        do_reset();
        wdt_en_i = 1'b1;
        do_step(2'd1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        plain_steps(PERIOD - 2, 2'd1);
        check("R7 no early time-out", 32'(rst_seen), 32'd0);
        check("R7 to flag before", 32'(to_flag_o), 32'd1);
        plain_steps(1, 2'd1);
        check("R7 time-out at period", 32'(wdt_rst_o), 32'd1);
        check("R12 to flag cleared", 32'(to_flag_o), 32'd0);
        check("R12 pd flag set", 32'(pd_flag_o), 32'd1);
        @(posedge clk_i);
        @(negedge clk_i);
        check("R12 one-cycle pulse", 32'(wdt_rst_o), 32'd0);
        wdt_en_i = 1'b0;
        t_snap = tmr_o;
        do_step(2'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R12 control restored, rising ignored", 32'(tmr_o), 32'(t_snap));
        do_step(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R12 control restored, falling counted", 32'(tmr_o), 32'(t_snap + 8'd1));
        do_step(2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R9 clear sets to flag", 32'(to_flag_o), 32'd1);

        // R8 postscaler with R9 scaler clear
        do_reset();
        wdt_en_i = 1'b1;
        do_step(2'd1, 1'b0, 1'b1, 8'h09, 1'b0, 8'h00, 1'b0, 1'b0);
        plain_steps(14, 2'd1);
        check("R8 one overflow is not enough", 32'(rst_seen), 32'd0);
        do_step(2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        plain_steps(19, 2'd1);
        check("R9 clear zeroed count and scaler", 32'(rst_seen), 32'd0);
        plain_steps(1, 2'd1);
        check("R8 time-out on second overflow", 32'(wdt_rst_o), 32'd1);

        // R10 sleep entry, R11 behaviour while asleep
        do_reset();
        wdt_en_i = 1'b1;
        do_step(2'd1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        plain_steps(4, 2'd1);
        do_step(2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
        check("R10 pd flag cleared", 32'(pd_flag_o), 32'd0);
        check("R10 to flag set", 32'(to_flag_o), 32'd1);
        t_snap = tmr_o;
        plain_steps(2, 2'd2);
        do_step(2'd2, 1'b1, 1'b1, 8'h20, 1'b1, 8'h55, 1'b0, 1'b0);
        plain_steps(1, 2'd2);
        do_step(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        plain_steps(4, 2'd2);
        check("R11 timer frozen, write ignored", 32'(tmr_o), 32'(t_snap));
        check("R11 clear ignored while asleep", 32'(pd_flag_o), 32'd0);
        check("R11 one tick per step", 32'(rst_seen), 32'd0);
        plain_steps(1, 2'd2);
        check("R11 time-out after period steps", 32'(wdt_rst_o), 32'd1);
        check("R12 wake on time-out", 32'(pd_flag_o), 32'd1);

        // R7 disabled watchdog never times out
        do_reset();
        wdt_en_i = 1'b0;
        do_step(2'd2, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        plain_steps(30, 2'd2);
        check("R7 disabled no time-out", 32'(rst_seen), 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule